// File: doc/BRIEF.md
# Add-on pass-through read responder

This block sits on the add-on side of a host-to-local bridge and serves host reads that the bridge forwards through its pass-through channel. When the bridge pulls the active-low attention line low, the responder checks the access status (region number, direction, byte enables). If the access is a full-word read of the served region, it accepts it. On the next clock it reads the host address that the bridge has latched. It then points its register select at the bridge's data register for the whole transfer.

During the transfer the responder drives data words from a small local memory model, beginning at the word index taken from the latched address. It holds the write strobe low for the whole transfer. It pulls the ready strobe low only in cycles where attention is present, so a host initiator that inserts wait states stalls the transfer without losing or repeating a word. A single read ends after one completed phase. A burst ends when the bridge releases its burst flag. After either ending, the responder waits a fixed hold-off before it will accept the next access.

Top module: `pt_read_responder`

## Requirements
- R1: While reset is asserted, and right after it is released, `sel_n`, `adr_rd_n`, `wr_n` and `rdy_n` are 1, `reg_ben_n` is 4'hF, `reg_addr` is 0 and `dout` is 0. Asserting reset in the middle of an access returns these values at once.
- R2: An access is accepted at a rising edge only when all of the following hold: `attn_n` is 0, `region` equals REGION (default 2'b01), `dir_wr` is 0 (1 means a write), and `ben_n` is 4'h0 (full word). Any other status leaves `sel_n` and `adr_rd_n` at 1.
- R3: In the cycle after acceptance, `adr_rd_n` is 0 for exactly one cycle. From that cycle until the transfer ends, `sel_n` is 0, `reg_ben_n` is 4'h0 and `reg_addr` is DATA_OFS (default 6'h2C).
- R4: `addr_in` is captured at the edge that ends the address cycle. Its word index is `addr_in >> 2` taken modulo DEPTH (default 16). The k-th delivered word is `mem[(index + k) mod DEPTH]`, where `mem[i] = {8'hA5, i[7:0], ~i[7:0], 8'h3C}`.
- R5: During the data transfer `wr_n` is 0 on every cycle. `rdy_n` is 0 exactly in the cycles where `attn_n` is 0 and the transfer is live. A phase completes at a rising edge where `rdy_n` is 0.
- R6: In a cycle where `attn_n` is 1, `rdy_n` is 1 and no phase completes. `dout` keeps the same pending word until a phase completes.
- R7: In a burst (`burst_n` 0 at acceptance), `burst_n` going to 1 ends the transfer. From that cycle on `rdy_n` stays 1 even if `attn_n` is 0, and after the next edge `wr_n` and `sel_n` are 1.
- R8: In a single read (`burst_n` 1 at acceptance), exactly one phase completes. After that edge `wr_n`, `rdy_n` and `sel_n` are 1.
- R9: After the edge that ends a transfer, the responder holds for HOLDOFF (default 2) cycles. The earliest edge that can accept a new access is the third edge after the ending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn_n | input | 1 | Active-low attention from the bridge; gates each data phase |
| burst_n | input | 1 | Active-low burst flag from the bridge |
| region | input | 2 | Pass-through region number of the access |
| dir_wr | input | 1 | Access direction, 1 = write, 0 = read |
| ben_n | input | 4 | Active-low byte enables of the access |
| addr_in | input | ADDR_W | Latched host address read from the bridge address register |
| sel_n | output | 1 | Active-low select of the bridge register interface |
| adr_rd_n | output | 1 | Active-low read of the bridge address register |
| reg_ben_n | output | 4 | Active-low byte enables on the register interface |
| reg_addr | output | REG_AW | Register offset on the register interface |
| wr_n | output | 1 | Active-low write strobe into the bridge data register |
| rdy_n | output | 1 | Active-low ready strobe completing a data phase |
| dout | output | DATA_W | Data word written into the bridge |

## Verification
Bursts are driven from a table of start addresses and wait-state masks. These cover stall-free runs, single stalls, alternating stalls and runs of stalls, with starts near the top of memory so that the index wraps. A wrong pending word, a skipped word and a duplicated word each show up as a different mismatch against the memory formula. Single reads with and without leading stalls separate the one-phase ending from the burst-flag ending. Directed cases feed a foreign region, a write and partial byte enables to show that acceptance is qualified. A back-to-back request right after a burst ends pins the exact hold-off edge.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } pt_state_e;

endpackage

// File: rtl/pt_status_decode.sv
module pt_status_decode #(
  parameter logic [1:0] REGION = 2'b01
) (
  input  logic       attn_n,
  input  logic [1:0] region,
  input  logic       dir_wr,
  input  logic [3:0] ben_n,
  output logic       req
);

  logic region_hit;
  logic full_read;

  assign region_hit = (region == REGION);
  assign full_read  = ~dir_wr & (ben_n == 4'h0);
  assign req        = ~attn_n & region_hit & full_read;

endmodule

// File: rtl/pt_seq_ctrl.sv
module pt_seq_ctrl
  import pt_pkg::*;
#(
  parameter int HOLDOFF = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      attn_n,
  input  logic      burst_n,
  output pt_state_e state,
  output logic      phase_done
);

  localparam int HCW = $clog2(HOLDOFF + 1);

  pt_state_e      state_q, state_d;
  logic           single_q, single_d;
  logic [HCW-1:0] hold_q, hold_d;
  logic           live;

  // a single read stays live until its one phase; a burst until the flag drops
  assign live       = single_q | ~burst_n;
  assign phase_done = (state_q == ST_DATA) & ~attn_n & live;

  always_comb begin
    state_d  = state_q;
    single_d = single_q;
    hold_d   = '0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d  = ST_ADDR;
          single_d = burst_n;
        end
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (!live || (phase_done && single_q)) begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (hold_q == HCW'(HOLDOFF - 1)) begin
          state_d = ST_IDLE;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b1;
      hold_q   <= '0;
    end else begin
      state_q  <= state_d;
      single_q <= single_d;
      hold_q   <= hold_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pt_word_store.sv
module pt_word_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       adv,
  input  logic [ADDR_W-1:0]          addr_in,
  output logic [$clog2(DEPTH)-1:0]   ptr,
  output logic [DATA_W-1:0]          word
);

  localparam int IW = $clog2(DEPTH);

  function automatic logic [DATA_W-1:0] fill(input int unsigned idx);
    logic [7:0] b;
    b = 8'(idx);
    return DATA_W'({8'hA5, b, ~b, 8'h3C});
  endfunction

  logic [DATA_W-1:0] rom [DEPTH];
  logic [IW-1:0]     ptr_q, ptr_d;
  logic              ptr_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = fill(g);
  end

  assign ptr_en = load | adv;

  always_comb begin
    if (load) begin
      ptr_d = IW'(addr_in >> 2);
    end else if (ptr_q == IW'(DEPTH - 1)) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr  = ptr_q;
  assign word = rom[ptr_q];

endmodule

// File: rtl/pt_read_responder.sv
module pt_read_responder
  import pt_pkg::*;
#(
  parameter int                DEPTH    = 16,
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 32,
  parameter int                REG_AW   = 6,
  parameter logic [REG_AW-1:0] DATA_OFS = 6'h2C,
  parameter logic [1:0]        REGION   = 2'b01,
  parameter int                HOLDOFF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attn_n,
  input  logic              burst_n,
  input  logic [1:0]        region,
  input  logic              dir_wr,
  input  logic [3:0]        ben_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              sel_n,
  output logic              adr_rd_n,
  output logic [3:0]        reg_ben_n,
  output logic [REG_AW-1:0] reg_addr,
  output logic              wr_n,
  output logic              rdy_n,
  output logic [DATA_W-1:0] dout
);

  localparam int IW = $clog2(DEPTH);

  pt_state_e         state;
  logic              req;
  logic              phase_done;
  logic              active;
  logic [IW-1:0]     word_ptr;
  logic [DATA_W-1:0] word;

  pt_status_decode #(
    .REGION (REGION)
  ) u_decode (
    .attn_n (attn_n),
    .region (region),
    .dir_wr (dir_wr),
    .ben_n  (ben_n),
    .req    (req)
  );

  pt_seq_ctrl #(
    .HOLDOFF (HOLDOFF)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .attn_n     (attn_n),
    .burst_n    (burst_n),
    .state      (state),
    .phase_done (phase_done)
  );

  pt_word_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state == ST_ADDR),
    .adv     (phase_done),
    .addr_in (addr_in),
    .ptr     (word_ptr),
    .word    (word)
  );

  assign active    = (state == ST_ADDR) | (state == ST_DATA);
  assign sel_n     = ~active;
  assign adr_rd_n  = ~(state == ST_ADDR);
  assign reg_ben_n = active ? 4'h0 : 4'hF;
  assign reg_addr  = active ? DATA_OFS : '0;
  assign wr_n      = ~(state == ST_DATA);
  assign rdy_n     = ~phase_done;
  assign dout      = (state == ST_DATA) ? word : '0;

endmodule

// File: rtl/pt_read_responder_chk.sv
module pt_read_responder_chk
  import pt_pkg::*;
#(
  parameter int         DATA_W  = 32,
  parameter int         IW      = 4,
  parameter logic [1:0] REGION  = 2'b01,
  parameter int         HOLDOFF = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              attn_n,
  input logic [1:0]        region,
  input logic              dir_wr,
  input logic              sel_n,
  input logic              adr_rd_n,
  input logic              wr_n,
  input logic              rdy_n,
  input logic [DATA_W-1:0] dout,
  input pt_state_e         st,
  input logic [IW-1:0]     ptr
);

  logic [7:0] idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run <= 8'hFF;
    end else if (sel_n) begin
      if (idle_run != 8'hFF) begin
        idle_run <= idle_run + 8'd1;
      end
    end else begin
      idle_run <= 8'd0;
    end
  end

  assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && (dir_wr || region != REGION)) |=> adr_rd_n);

  assert_addr_read_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_rd_n |=> adr_rd_n);

  assert_ready_needs_attn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> (!attn_n && !wr_n));

  assert_stall_holds_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && attn_n) |=> (wr_n || $stable(dout)));

  assert_ptr_waits_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && rdy_n) |=> $stable(ptr));

  assert_holdoff_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adr_rd_n) |-> (idle_run >= 8'(HOLDOFF + 1)));

endmodule

bind pt_read_responder pt_read_responder_chk #(
  .DATA_W  (DATA_W),
  .IW      (IW),
  .REGION  (REGION),
  .HOLDOFF (HOLDOFF)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .attn_n   (attn_n),
  .region   (region),
  .dir_wr   (dir_wr),
  .sel_n    (sel_n),
  .adr_rd_n (adr_rd_n),
  .wr_n     (wr_n),
  .rdy_n    (rdy_n),
  .dout     (dout),
  .st       (state),
  .ptr      (word_ptr)
);

// File: tb/test_pt_read_responder.sv
`timescale 1ns/1ps
module test_pt_read_responder;

  localparam int DEPTH = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  n;
    logic        burst;
    logic [15:0] drops;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 8'd4, 1'b1, 16'h0000},
    '{32'h0000_0034, 8'd6, 1'b1, 16'b0000_0001_1001_0100},
    '{32'h0000_0008, 8'd1, 1'b0, 16'h0000},
    '{32'h0000_0020, 8'd1, 1'b0, 16'h0007},
    '{32'h0000_003C, 8'd3, 1'b1, 16'hAAAA},
    '{32'h1000_0014, 8'd9, 1'b1, 16'h0C30}
  };

  logic        clk;
  logic        rst_n;
  logic        attn_n;
  logic        burst_n;
  logic [1:0]  region;
  logic        dir_wr;
  logic [3:0]  ben_n;
  logic [31:0] addr_in;
  logic        sel_n;
  logic        adr_rd_n;
  logic [3:0]  reg_ben_n;
  logic [5:0]  reg_addr;
  logic        wr_n;
  logic        rdy_n;
  logic [31:0] dout;

  int n_checks;
  int n_fail;
  bit done;

  pt_read_responder i_pt_read_responder (
    .clk       (clk),
    .rst_n     (rst_n),
    .attn_n    (attn_n),
    .burst_n   (burst_n),
    .region    (region),
    .dir_wr    (dir_wr),
    .ben_n     (ben_n),
    .addr_in   (addr_in),
    .sel_n     (sel_n),
    .adr_rd_n  (adr_rd_n),
    .reg_ben_n (reg_ben_n),
    .reg_addr  (reg_addr),
    .wr_n      (wr_n),
    .rdy_n     (rdy_n),
    .dout      (dout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input int unsigned i);
    logic [7:0] b;
    b = 8'(i);
    return {8'hA5, b, ~b, 8'h3C};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    attn_n  = 1'b1;
    burst_n = 1'b1;
    region  = 2'b00;
    dir_wr  = 1'b0;
    ben_n   = 4'hF;
    addr_in = '0;
  endtask

  task automatic check_idle_outputs(input string req);
    check(sel_n == 1'b1,     req, "sel_n",     32'(sel_n),     32'h1);
    check(adr_rd_n == 1'b1,  req, "adr_rd_n",  32'(adr_rd_n),  32'h1);
    check(wr_n == 1'b1,      req, "wr_n",      32'(wr_n),      32'h1);
    check(rdy_n == 1'b1,     req, "rdy_n",     32'(rdy_n),     32'h1);
    check(reg_ben_n == 4'hF, req, "reg_ben_n", 32'(reg_ben_n), 32'hF);
    check(reg_addr == 6'h0,  req, "reg_addr",  32'(reg_addr),  32'h0);
    check(dout == 32'h0,     req, "dout",      dout,           32'h0);
  endtask

  // bridge model: request, supply address, pace phases, end the access
  task automatic run_access(input vec_t v, input bit back_to_back);
    int got;
    int c;
    int unsigned start;
    logic [31:0] exp;
    got   = 0;
    c     = 0;
    start = (v.addr >> 2) % DEPTH;
    @(negedge clk);
    attn_n  = 1'b0;
    burst_n = ~v.burst;
    region  = 2'b01;
    dir_wr  = 1'b0;
    ben_n   = 4'h0;
    @(negedge clk);
    #1;
    check(adr_rd_n == 1'b0,  "R3", "adr_rd_n in address cycle", 32'(adr_rd_n), 32'h0);
    check(sel_n == 1'b0,     "R3", "sel_n in address cycle", 32'(sel_n), 32'h0);
    check(reg_addr == 6'h2C, "R3", "reg_addr offset", 32'(reg_addr), 32'h2C);
    check(reg_ben_n == 4'h0, "R3", "reg_ben_n", 32'(reg_ben_n), 32'h0);
    addr_in = v.addr;
    @(negedge clk);
    while (got < int'(v.n) && c < 200) begin
      attn_n = v.drops[c % 16];
      c++;
      #1;
      exp = mem_word((start + got) % DEPTH);
      check(wr_n == 1'b0,     "R5", "wr_n in data phase", 32'(wr_n), 32'h0);
      check(adr_rd_n == 1'b1, "R3", "adr_rd_n after address cycle", 32'(adr_rd_n), 32'h1);
      check(sel_n == 1'b0,    "R3", "sel_n held in data phase", 32'(sel_n), 32'h0);
      check(rdy_n == attn_n,  "R5", "rdy_n follows attention", 32'(rdy_n), 32'(attn_n));
      if (attn_n) begin
        check(dout == exp, "R6", "pending word during stall", dout, exp);
      end else begin
        check(dout == exp, "R4", "delivered word", dout, exp);
        got++;
      end
      @(negedge clk);
    end
    if (v.burst) begin
      burst_n = 1'b1;
      attn_n  = 1'b0;
      #1;
      check(rdy_n == 1'b1, "R7", "no ready after burst flag drops", 32'(rdy_n), 32'h1);
      @(negedge clk);
      #1;
      check(wr_n == 1'b1,  "R7", "wr_n after burst end", 32'(wr_n), 32'h1);
      check(sel_n == 1'b1, "R7", "sel_n after burst end", 32'(sel_n), 32'h1);
    end else begin
      #1;
      check(wr_n == 1'b1,  "R8", "wr_n after single phase", 32'(wr_n), 32'h1);
      check(rdy_n == 1'b1, "R8", "rdy_n after single phase", 32'(rdy_n), 32'h1);
      check(sel_n == 1'b1, "R8", "sel_n after single phase", 32'(sel_n), 32'h1);
    end
    if (back_to_back) begin
      // new burst request from the first cycle of the hold-off
      burst_n = 1'b0;
      attn_n  = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        #1;
        check(adr_rd_n == 1'b1, "R9", "no acceptance inside hold-off", 32'(adr_rd_n), 32'h1);
      end
      @(negedge clk);
      #1;
      check(adr_rd_n == 1'b0, "R9", "acceptance at third edge", 32'(adr_rd_n), 32'h0);
    end else begin
      attn_n = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    idle_inputs();
    #1;
    check_idle_outputs("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_idle_outputs("R1");

    for (int i = 0; i < 6; i++) begin
      run_access(VECS[i], 1'b0);
    end

    // R2: foreign region, write direction, partial byte enables
    @(negedge clk);
    attn_n = 1'b0; region = 2'b10; dir_wr = 1'b0; ben_n = 4'h0;
    repeat (2) @(negedge clk);
    #1;
    check(sel_n == 1'b1, "R2", "foreign region ignored", 32'(sel_n), 32'h1);
    region = 2'b01; dir_wr = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(sel_n == 1'b1, "R2", "write access ignored", 32'(sel_n), 32'h1);
    dir_wr = 1'b0; ben_n = 4'h3;
    repeat (2) @(negedge clk);
    #1;
    check(adr_rd_n == 1'b1, "R2", "partial byte enables ignored", 32'(adr_rd_n), 32'h1);
    idle_inputs();
    repeat (2) @(negedge clk);

    // R9: request again right after a burst ends
    v = '{32'h0000_0018, 8'd2, 1'b1, 16'h0002};
    run_access(v, 1'b1);

    // R1: reset in the middle of an access
    rst_n = 1'b0;
    idle_inputs();
    #1;
    check_idle_outputs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // a burst after reset still starts cleanly
    run_access(VECS[1], 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule